// File: doc/BRIEF.md
# Bit-Serial Fixed-Point 9/7 Lifting Wavelet Core

This core produces one low-pass and one high-pass coefficient of a 9/7 biorthogonal wavelet transform from a window of nine 8-bit signed samples. The lifting steps are folded into a single direct expression over the window. Every constant product uses an integer scaled constant, and every sum uses an 8-bit adder that drops its least significant bit, so all intermediate values stay 8-bit signed.

Samples reach the core on one serial data line. While the capture enable is high, one bit enters per clock. The folded expression is then evaluated through a four-register pipeline. When the unload strobe goes high, the two 8-bit results are shifted out together on two single-bit pins, one bit per clock. A host streams a window in, waits for the pipeline to settle, and pulses the unload strobe for eight clocks to read both coefficients.

Top module: `dwt_lift_core`

## Requirements
- R1: While `en` is high, each rising clock edge shifts `ser_in` into a 72-bit capture chain. A window takes 72 clocks. The nine samples are sent in order x-4, x-3, ..., x+4, and each sample is sent most significant bit first.
- R2: While `en` is low, `ser_in` has no effect and the captured samples hold their values.
- R3: Every sum is the truncating add A(a,b) = floor((a+b)/2) of two 8-bit signed operands.
- R4: Every constant product is M(v,K,s) = floor(v*K / 2^s), clamped to the range -128..127.
- R5: With Er=A(x0,x2), El=A(x0,x-2), Or=A(x2,x4), Pr=A(M(Er,57,5),x1), Pl=A(M(El,57,5),x-1) and Qr=A(M(Or,57,5),x3), the high-pass output is di = A(A(Pr, M(A(Pl,Qr),6,8)), M(Er,30,6)).
- R6: With Ol=A(x-2,x-4), Ql=A(M(Ol,57,5),x-3) and S=A(Er,El), the low-pass output is ai = A(A(M(A(Pl,Pr),35,5), M(A(Ql,Qr),12,8)), A(M(S,26,5), M(x0,50,5))).
- R7: The result is taken from four pipeline registers. An unload that starts on the fifth rising edge after the last capture edge, or on any later edge, delivers the coefficients of that window.
- R8: On the first rising edge where `piso_load` is high, both results are loaded and their most significant bits appear on `ai` and `di`. Each further edge with `piso_load` high shifts both outputs toward the least significant bit, so the eight bits appear over eight edges.
- R9: While `piso_load` is low, `ai` and `di` hold their values.
- R10: A synchronous active-high `rst` clears the capture chain, the pipeline registers and the output registers, so `ai` and `di` read 0 after the reset edge.
- R11: When `piso_load` is raised again with no new capture in between, the same coefficients are delivered again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable for the serial sample stream |
| ser_in | input | 1 | Serial sample data |
| piso_load | input | 1 | Unload strobe: loads on its first high cycle, then shifts |
| ai | output | 1 | Serial low-pass coefficient, MSB first |
| di | output | 1 | Serial high-pass coefficient, MSB first |

## Verification
The bench drives windows made entirely of +127 and of -128. These push the 57/32 product past the 8-bit range. A design that wraps instead of clamping gives an output with the wrong sign, and a design that rounds the dropped bit instead of flooring is off by one on negative sums. Alternating-extreme and random windows catch a mis-ordered tap or a sample captured in reverse bit order, because they produce asymmetric sums. The bench also toggles `ser_in` with `en` low and then unloads again, which exposes a capture chain that keeps shifting. Idle cycles after each unload show whether the output shifter drifts when the strobe is low. A reset in the middle of a run is followed by an unload that must return all zeros.

// File: rtl/lift_dwt_pkg.sv
package lift_dwt_pkg;

    localparam int SMP_W    = 8;
    localparam int TAPS     = 9;
    localparam int CAP_BITS = SMP_W * TAPS;
    localparam int SMP_MAX  = (2 ** (SMP_W - 1)) - 1;
    localparam int SMP_MIN  = -(2 ** (SMP_W - 1));

    // integer scaled lifting constants and their scale exponents
    localparam int ALPHA_K = 57;  localparam int ALPHA_SH = 5;
    localparam int GB_K    = 6;   localparam int GB_SH    = 8;
    localparam int GE_K    = 30;  localparam int GE_SH    = 6;
    localparam int AIN_K   = 35;  localparam int AIN_SH   = 5;
    localparam int AOUT_K  = 12;  localparam int AOUT_SH  = 8;
    localparam int EVN_K   = 26;  localparam int EVN_SH   = 5;
    localparam int ZETA_K  = 50;  localparam int ZETA_SH  = 5;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic [TAPS-1:0][SMP_W-1:0] window_t;

    typedef struct packed {
        smp_t ev_r;
        smp_t ev_l;
        smp_t od_r;
        smp_t od_l;
    } pair_st;

    typedef struct packed {
        smp_t pr;
        smp_t pl;
        smp_t qr;
        smp_t ql;
        smp_t es;
    } lift_st;

    typedef struct packed {
        smp_t d_a;
        smp_t d_b;
        smp_t d_c;
        smp_t a_a;
        smp_t a_b;
        smp_t a_c;
        smp_t a_d;
    } wgt_st;

    typedef struct packed {
        smp_t ai;
        smp_t di;
    } res_st;

    // sum of two samples with the LSB of the 9-bit result dropped
    function automatic smp_t add_trunc(smp_t a, smp_t b);
        logic signed [SMP_W:0] s;
        s = {a[SMP_W-1], a} + {b[SMP_W-1], b};
        return s[SMP_W:1];
    endfunction

    // constant product, arithmetic rescale, clamp to sample range
    function automatic smp_t cmul_sat(smp_t v, int k, int sh);
        logic signed [31:0] p;
        p = v * k;
        p = p >>> sh;
        if (p > SMP_MAX)
            return smp_t'(SMP_MAX);
        else if (p < SMP_MIN)
            return smp_t'(SMP_MIN);
        else
            return p[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/lift_capture.sv
module lift_capture
    import lift_dwt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    ser_in,
    output window_t win
);

    logic [CAP_BITS-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else if (en)
            chain_q <= {chain_q[CAP_BITS-2:0], ser_in};
    end

    // oldest bit ends at the top: x-4 in element TAPS-1
    assign win = chain_q;

    // R1
    cap_shift_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> chain_q[0] == $past(ser_in));

    // R2
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(chain_q));

    // R10
    cap_clear_chk: assert property (@(posedge clk)
        rst |=> chain_q == '0);

endmodule

// File: rtl/lift_datapath.sv
module lift_datapath
    import lift_dwt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  window_t win,
    output res_st   res
);

    smp_t xm4, xm3, xm2, xm1, x0, xp1, xp2, xp3, xp4;

    assign xm4 = win[8];
    assign xm3 = win[7];
    assign xm2 = win[6];
    assign xm1 = win[5];
    assign x0  = win[4];
    assign xp1 = win[3];
    assign xp2 = win[2];
    assign xp3 = win[1];
    assign xp4 = win[0];

    pair_st pair_q;
    lift_st lift_q;
    wgt_st  wgt_q;
    res_st  res_q;

    // stage 1: even pair sums
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else begin
            pair_q.ev_r <= add_trunc(x0, xp2);
            pair_q.ev_l <= add_trunc(x0, xm2);
            pair_q.od_r <= add_trunc(xp2, xp4);
            pair_q.od_l <= add_trunc(xm2, xm4);
        end
    end

    // stage 2: predicted terms and even total
    always_ff @(posedge clk) begin
        if (rst) begin
            lift_q <= '0;
        end else begin
            lift_q.pr <= add_trunc(cmul_sat(pair_q.ev_r, ALPHA_K, ALPHA_SH), xp1);
            lift_q.pl <= add_trunc(cmul_sat(pair_q.ev_l, ALPHA_K, ALPHA_SH), xm1);
            lift_q.qr <= add_trunc(cmul_sat(pair_q.od_r, ALPHA_K, ALPHA_SH), xp3);
            lift_q.ql <= add_trunc(cmul_sat(pair_q.od_l, ALPHA_K, ALPHA_SH), xm3);
            lift_q.es <= add_trunc(pair_q.ev_r, pair_q.ev_l);
        end
    end

    // stage 3: weighted terms
    always_ff @(posedge clk) begin
        if (rst) begin
            wgt_q <= '0;
        end else begin
            wgt_q.d_a <= lift_q.pr;
            wgt_q.d_b <= cmul_sat(add_trunc(lift_q.pl, lift_q.qr), GB_K, GB_SH);
            wgt_q.d_c <= cmul_sat(pair_q.ev_r, GE_K, GE_SH);
            wgt_q.a_a <= cmul_sat(add_trunc(lift_q.pl, lift_q.pr), AIN_K, AIN_SH);
            wgt_q.a_b <= cmul_sat(add_trunc(lift_q.ql, lift_q.qr), AOUT_K, AOUT_SH);
            wgt_q.a_c <= cmul_sat(lift_q.es, EVN_K, EVN_SH);
            wgt_q.a_d <= cmul_sat(x0, ZETA_K, ZETA_SH);
        end
    end

    // stage 4: final sums
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.di <= add_trunc(add_trunc(wgt_q.d_a, wgt_q.d_b), wgt_q.d_c);
            res_q.ai <= add_trunc(add_trunc(wgt_q.a_a, wgt_q.a_b),
                                  add_trunc(wgt_q.a_c, wgt_q.a_d));
        end
    end

    assign res = res_q;

    // R10
    dp_clear_chk: assert property (@(posedge clk)
        rst |=> (res_q == '0 && wgt_q == '0 && lift_q == '0 && pair_q == '0));

    // R7
    dp_settle_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(win) && $stable(pair_q) && $stable(lift_q) && $stable(wgt_q))
            |=> $stable(res_q));

endmodule

// File: rtl/lift_piso.sv
module lift_piso #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] par,
    output logic         ser
);

    logic [W-1:0] sh_q;
    logic         ld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            ld_q <= 1'b0;
        end else begin
            ld_q <= load;
            if (load && !ld_q)
                sh_q <= par;
            else if (load)
                sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign ser = sh_q[W-1];

    // R8
    piso_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !ld_q) |=> ser == $past(par[W-1]));

    // R8
    piso_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (load && ld_q) |=> ser == $past(sh_q[W-2]));

    // R9
    piso_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(sh_q));

    // R10
    piso_clear_chk: assert property (@(posedge clk)
        rst |=> (sh_q == '0 && !ser));

endmodule

// File: rtl/dwt_lift_core.sv
module dwt_lift_core
    import lift_dwt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ser_in,
    input  logic piso_load,
    output logic ai,
    output logic di
);

    localparam int LANES = 2;

    window_t win;
    res_st   res;
    logic [LANES-1:0][SMP_W-1:0] lane_par;
    logic [LANES-1:0]            lane_ser;

    lift_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ser_in (ser_in),
        .win    (win)
    );

    lift_datapath u_dp (
        .clk (clk),
        .rst (rst),
        .win (win),
        .res (res)
    );

    assign lane_par[0] = res.ai;
    assign lane_par[1] = res.di;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lift_piso #(.W(SMP_W)) u_piso (
            .clk  (clk),
            .rst  (rst),
            .load (piso_load),
            .par  (lane_par[g]),
            .ser  (lane_ser[g])
        );
    end

    assign ai = lane_ser[0];
    assign di = lane_ser[1];

endmodule

// File: tb/dwt_lift_core_tb_top.sv
module dwt_lift_core_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic ser_in = 1'b0;
    logic piso_load = 1'b0;
    logic ai, di;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    logic [15:0] last_exp = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dwt_lift_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ser_in    (ser_in),
        .piso_load (piso_load),
        .ai        (ai),
        .di        (di)
    );

    // R3 truncating add
    function automatic int ta(int a, int b);
        return (a + b) >>> 1;
    endfunction

    // R4 clamped constant product
    function automatic int cm(int v, int k, int s);
        int p;
        p = (v * k) >>> s;
        if (p > 127) p = 127;
        if (p < -128) p = -128;
        return p;
    endfunction

    // x[0]=x-4 ... x[4]=x0 ... x[8]=x+4
    function automatic logic [15:0] ref_fn(input int x[9]);
        int er, el, od_r, od_l, pr, pl, qr, ql, s, dv, av;
        logic [7:0] ab, db;
        er   = ta(x[4], x[6]);
        el   = ta(x[4], x[2]);
        od_r = ta(x[6], x[8]);
        od_l = ta(x[2], x[0]);
        pr   = ta(cm(er, 57, 5), x[5]);
        pl   = ta(cm(el, 57, 5), x[3]);
        qr   = ta(cm(od_r, 57, 5), x[7]);
        ql   = ta(cm(od_l, 57, 5), x[1]);
        s    = ta(er, el);
        dv   = ta(ta(pr, cm(ta(pl, qr), 6, 8)), cm(er, 30, 6));
        av   = ta(ta(cm(ta(pl, pr), 35, 5), cm(ta(ql, qr), 12, 8)),
                  ta(cm(s, 26, 5), cm(x[4], 50, 5)));
        ab = av[7:0];
        db = dv[7:0];
        return {ab, db};
    endfunction

    task automatic unload(input logic [15:0] e);
        exp_q.push_back(e);
        last_exp = e;
        @(negedge clk) piso_load = 1'b1;
        repeat (8) @(negedge clk);
        piso_load = 1'b0;
        // R9 outputs hold the last bit while the strobe is low
        repeat (3) @(negedge clk);
        checks++;
        if (ai !== e[8] || di !== e[0]) begin
            errors++;
            $display("FAIL R9 hold: ai=%b di=%b expected ai=%b di=%b", ai, di, e[8], e[0]);
        end
    endtask

    // R1 capture order, then R7 wait of six idle edges before unload
    task automatic send_window(input int x[9]);
        for (int i = 0; i < 9; i++) begin
            logic [7:0] v;
            v = x[i][7:0];
            for (int b = 7; b >= 0; b--) begin
                @(negedge clk);
                en = 1'b1;
                ser_in = v[b];
            end
        end
        @(negedge clk);
        en = 1'b0;
        ser_in = 1'b0;
        repeat (5) @(negedge clk);
        unload(ref_fn(x));
    endtask

    // monitor: collects eight serial bits per unload and pops the scoreboard
    initial begin
        logic [7:0] acol, dcol;
        int n;
        n = 0;
        acol = '0;
        dcol = '0;
        forever begin
            @(posedge clk);
            #2;
            if (!rst && piso_load) begin
                acol = {acol[6:0], ai};
                dcol = {dcol[6:0], di};
                n++;
                if (n == 8) begin
                    logic [15:0] e;
                    n = 0;
                    checks += 2;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R8 unexpected unload: ai=%0d di=%0d expected none",
                                 $signed(acol), $signed(dcol));
                    end else begin
                        e = exp_q.pop_front();
                        // R6 low-pass value (covers R1 R3 R4 R7 R8)
                        if (acol !== e[15:8]) begin
                            errors++;
                            $display("FAIL R6 ai: got %0d expected %0d",
                                     $signed(acol), $signed(e[15:8]));
                        end
                        // R5 high-pass value
                        if (dcol !== e[7:0]) begin
                            errors++;
                            $display("FAIL R5 di: got %0d expected %0d",
                                     $signed(dcol), $signed(e[7:0]));
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w[9];
        repeat (3) @(negedge clk);
        // R10 reset state
        checks++;
        if (ai !== 1'b0 || di !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset outputs: ai=%b di=%b expected 0 0", ai, di);
        end
        rst = 1'b0;
        @(negedge clk);

        // all maximum: saturating products (R4)
        for (int i = 0; i < 9; i++) w[i] = 127;
        send_window(w);
        // all minimum
        for (int i = 0; i < 9; i++) w[i] = -128;
        send_window(w);
        // alternating extremes
        for (int i = 0; i < 9; i++) w[i] = (i % 2 == 0) ? 127 : -128;
        send_window(w);
        for (int i = 0; i < 9; i++) w[i] = (i % 2 == 0) ? -128 : 127;
        send_window(w);
        // ramp, asymmetric about the centre (R1 ordering)
        for (int i = 0; i < 9; i++) w[i] = i * 13 - 50;
        send_window(w);
        // single centre impulse
        for (int i = 0; i < 9; i++) w[i] = (i == 4) ? 100 : 0;
        send_window(w);
        // random windows
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 9; i++) w[i] = int'($urandom_range(0, 255)) - 128;
            send_window(w);
        end

        // R2 toggle ser_in with en low, then R11 unload again
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            ser_in = k[0];
        end
        ser_in = 1'b0;
        unload(last_exp);

        // R10 reset in the middle of a capture
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            en = 1'b1;
            ser_in = ~k[1];
        end
        @(negedge clk);
        en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (ai !== 1'b0 || di !== 1'b0) begin
            errors++;
            $display("FAIL R10 mid-run reset: ai=%b di=%b expected 0 0", ai, di);
        end
        rst = 1'b0;
        repeat (6) @(negedge clk);
        unload(16'h0000);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing unloads: pending=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule